// File: doc/BRIEF.md
# Processor Interrupt Response Sequencer

This block sits beside the instruction decoder of a small 8-bit processor core and decides when and how an interrupt is taken. It watches a nonmaskable interrupt line for rising edges, samples a level-sensitive maskable request at instruction boundaries, and holds the two interrupt-enable bits and the maskable response mode. The decoder drives it with one-cycle strobes: enable, disable, mode select and return from nonmaskable service.

When a request is taken, the sequencer raises `busy_o` so that the core stalls. A maskable request first runs an acknowledge cycle that includes two inserted wait states, and the requesting device's byte is captured on its final clock. What follows depends on the mode: a fixed restart, a vectored indirect call through a table in memory, or the execution of the device's byte as an instruction. In that last case the device may supply a restart opcode, a three-byte call whose operands are fetched, or any other opcode, which is handed to the core.

For every call, the sequencer presents the return address to the stack datapath one byte at a time and then issues the jump target.

Top module: `intr_response_ctl`

## Requirements
- R1: After reset the live enable bit and the saved enable bit are both 0, the mode is 0, and `busy_o` and every strobe output are low.
- R2: The enable strobe sets both enable bits and the disable strobe clears both. The mode strobe loads `mode_sel` when it is 0, 1 or 2; the value 3 leaves the mode unchanged.
- R3: A rising edge on `nmi_in` is held pending until the next instruction boundary, however many cycles later, and is taken whatever the enable bits hold. It runs no acknowledge cycle, clears the live enable bit, keeps the saved bit, pushes the return address and jumps to 0x0066.
- R4: The return-from-nonmaskable strobe copies the saved enable bit into the live enable bit.
- R5: A maskable request is taken only at an instruction boundary, only while the live bit is 1 and only when no nonmaskable request is pending. Taking it clears both enable bits. While the live bit is 0 the request is ignored and `busy_o` stays low.
- R6: When a nonmaskable request is pending at the same boundary as an enabled maskable request, the nonmaskable request is served.
- R7: Every maskable acknowledge holds `ack_o` high for exactly ACK_BASE+ACK_WAITS cycles (4 by default: two base clocks plus two wait states). The device byte is captured in the last of these cycles.
- R8: In mode 1 the device byte is ignored and the request calls 0x0038.
- R9: In mode 0, a device byte of the form 11nnn111 (binary) is a restart: the sequencer calls address nnn*8.
- R10: In mode 0, the device byte 0xCD is a call. It is followed by two `oper_o` cycles that capture the low and then the high target byte from `bus_data`, and the sequencer then calls that address.
- R11: In mode 0, any other device byte is presented on `inject_data_o` with `inject_o` high for one cycle, with no push and no jump.
- R12: In mode 2, the sequencer reads the table at {page_reg, device byte with bit 0 cleared} for the low target byte and then at that address plus one for the high byte, and then calls the assembled address.
- R13: Every call pushes `pc_ret` (sampled when the request is taken) as the high byte and then the low byte in two consecutive `push_o` cycles. `jump_o` follows in the next cycle. At most one strobe output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Nonmaskable request; rising edge is significant |
| irq_in | input | 1 | Maskable request level |
| at_boundary | input | 1 | Core is between instructions this cycle |
| int_en_stb | input | 1 | Enable-interrupts strobe |
| int_dis_stb | input | 1 | Disable-interrupts strobe |
| mode_stb | input | 1 | Load response mode strobe |
| mode_sel | input | 2 | Mode value for `mode_stb` |
| nmi_ret_stb | input | 1 | Return-from-nonmaskable strobe |
| page_reg | input | 8 | High byte of the mode-2 vector table address |
| pc_ret | input | 16 | Return address offered by the core |
| bus_data | input | 8 | Data bus: device byte, operand bytes, table bytes |
| ack_o | output | 1 | Interrupt acknowledge cycle active |
| oper_o | output | 1 | Mode-0 call operand byte being read |
| tbl_rd_o | output | 1 | Vector table read |
| tbl_addr_o | output | 16 | Vector table read address |
| push_o | output | 1 | Push one return-address byte |
| push_data_o | output | 8 | Byte to push |
| jump_o | output | 1 | Load the program counter |
| jump_addr_o | output | 16 | Jump target |
| inject_o | output | 1 | Execute the device byte as the next opcode |
| inject_data_o | output | 8 | Device byte to execute |
| busy_o | output | 1 | Response sequence in progress |
| ie_live_o | output | 1 | Live interrupt-enable bit |
| ie_saved_o | output | 1 | Saved interrupt-enable bit |
| mode_o | output | 2 | Current maskable response mode |

## Verification
Properties check several behaviours on every cycle:
- the length of each acknowledge cycle;
- that both enable bits are cleared as an acknowledge starts;
- that the saved bit survives a nonmaskable acceptance;
- the copy-back on return;
- the high-then-low push pair followed directly by a jump;
- the even-then-odd table addresses;
- mutual exclusion of the strobes.

The jump targets of each mode, the opcode classification in mode 0 and the operand and table data paths depend on stimulus and expected values. So do the priority of a nonmaskable request over a maskable one, a pending edge that waits several cycles for a boundary, and a request ignored while interrupts are disabled. Only the bench's scenarios, scored event by event against a queue of expected results, can show these.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK,
    ST_OP_LO,
    ST_OP_HI,
    ST_TB_LO,
    ST_TB_HI,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_JUMP,
    ST_INJECT
  } seq_state_t;

  typedef enum logic [1:0] {
    RK_RESTART,
    RK_CALL,
    RK_TABLE,
    RK_INJECT
  } resp_kind_t;

  localparam logic [1:0] MODE_INJECT  = 2'd0;
  localparam logic [1:0] MODE_RESTART = 2'd1;
  localparam logic [1:0] MODE_TABLE   = 2'd2;

endpackage

// File: rtl/intr_enable_regs.sv
module intr_enable_regs
  import intr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_stb,
  input  logic       dis_stb,
  input  logic       mode_stb,
  input  logic [1:0] mode_sel,
  input  logic       ret_stb,
  input  logic       take_nmi,
  input  logic       take_irq,
  output logic       ie_live_q,
  output logic       ie_saved_q,
  output logic [1:0] mode_q
);

  logic       ie_live_d;
  logic       ie_saved_d;
  logic [1:0] mode_d;
  logic       flag_en;
  logic       mode_en;

  // Acceptance outranks decoder strobes; among strobes, return outranks enable/disable.
  always_comb begin
    ie_live_d  = ie_live_q;
    ie_saved_d = ie_saved_q;
    if (take_irq) begin
      ie_live_d  = 1'b0;
      ie_saved_d = 1'b0;
    end else if (take_nmi) begin
      ie_live_d  = 1'b0;
    end else if (ret_stb) begin
      ie_live_d  = ie_saved_q;
    end else if (en_stb) begin
      ie_live_d  = 1'b1;
      ie_saved_d = 1'b1;
    end else if (dis_stb) begin
      ie_live_d  = 1'b0;
      ie_saved_d = 1'b0;
    end
  end

  assign flag_en = take_irq | take_nmi | ret_stb | en_stb | dis_stb;
  assign mode_en = mode_stb & (mode_sel != 2'd3);
  assign mode_d  = mode_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_live_q  <= 1'b0;
      ie_saved_q <= 1'b0;
    end else if (flag_en) begin
      ie_live_q  <= ie_live_d;
      ie_saved_q <= ie_saved_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INJECT;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend_q
);

  logic prev_q;
  logic rise;
  logic pend_d;

  assign rise   = nmi_in & ~prev_q;
  // A fresh edge in the cycle of acceptance stays pending for the next boundary.
  assign pend_d = (pend_q & ~take) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_in;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/intr_vector_calc.sv
module intr_vector_calc
  import intr_pkg::*;
#(
  parameter logic [AW-1:0] IM1_TARGET  = 16'h0038,
  parameter logic [DW-1:0] CALL_OPCODE = 8'hCD
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] page,
  output resp_kind_t    kind,
  output logic [AW-1:0] addr
);

  localparam int RST_SHIFT = 3;

  logic is_rst_op;
  assign is_rst_op = (vec[7:6] == 2'b11) && (vec[2:0] == 3'b111);

  always_comb begin
    kind = RK_INJECT;
    addr = '0;
    case (mode)
      MODE_RESTART: begin
        kind = RK_RESTART;
        addr = IM1_TARGET;
      end
      MODE_TABLE: begin
        kind = RK_TABLE;
        addr = {page, vec[DW-1:1], 1'b0};
      end
      default: begin
        if (vec == CALL_OPCODE) begin
          kind = RK_CALL;
        end else if (is_rst_op) begin
          kind = RK_RESTART;
          addr = AW'({vec[5:3], {RST_SHIFT{1'b0}}});
        end else begin
          kind = RK_INJECT;
        end
      end
    endcase
  end

endmodule

// File: rtl/intr_resp_seq.sv
module intr_resp_seq
  import intr_pkg::*;
#(
  parameter int            ACK_LEN    = 4,
  parameter logic [AW-1:0] NMI_TARGET = 16'h0066
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_boundary,
  input  logic          nmi_pend,
  input  logic          irq_in,
  input  logic          ie_live,
  input  resp_kind_t    calc_kind,
  input  logic [AW-1:0] calc_addr,
  input  logic [AW-1:0] pc_ret,
  input  logic [DW-1:0] bus_data,
  output logic          take_nmi,
  output logic          take_irq,
  output logic          ack_o,
  output logic          oper_o,
  output logic          tbl_rd_o,
  output logic [AW-1:0] tbl_addr_o,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          jump_o,
  output logic [AW-1:0] jump_addr_o,
  output logic          inject_o,
  output logic [DW-1:0] inject_data_o,
  output logic          busy_o
);

  localparam int          CW       = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;
  localparam logic [CW-1:0] ACK_LAST = CW'(ACK_LEN - 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [DW-1:0] lo_q, lo_d;
  logic [DW-1:0] inj_q;
  logic          ret_en;
  logic          inj_en;
  logic          cnt_en;
  logic          tgt_en;
  logic          lo_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tgt_d    = tgt_q;
    lo_d     = lo_q;
    take_nmi = 1'b0;
    take_irq = 1'b0;
    inj_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (at_boundary) begin
          if (nmi_pend) begin
            take_nmi = 1'b1;
            tgt_d    = NMI_TARGET;
            state_d  = ST_PUSH_HI;
          end else if (irq_in && ie_live) begin
            take_irq = 1'b1;
            cnt_d    = '0;
            state_d  = ST_ACK;
          end
        end
      end
      ST_ACK: begin
        if (cnt_q == ACK_LAST) begin
          case (calc_kind)
            RK_RESTART: begin
              tgt_d   = calc_addr;
              state_d = ST_PUSH_HI;
            end
            RK_TABLE: begin
              tgt_d   = calc_addr;
              state_d = ST_TB_LO;
            end
            RK_CALL: begin
              state_d = ST_OP_LO;
            end
            default: begin
              inj_en  = 1'b1;
              state_d = ST_INJECT;
            end
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OP_LO: begin
        lo_d    = bus_data;
        state_d = ST_OP_HI;
      end
      ST_OP_HI: begin
        tgt_d   = {bus_data, lo_q};
        state_d = ST_PUSH_HI;
      end
      ST_TB_LO: begin
        lo_d    = bus_data;
        state_d = ST_TB_HI;
      end
      ST_TB_HI: begin
        tgt_d   = {bus_data, lo_q};
        state_d = ST_PUSH_HI;
      end
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_JUMP;
      ST_JUMP:    state_d = ST_IDLE;
      ST_INJECT:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign ret_en = take_nmi | take_irq;
  assign cnt_en = (state_q == ST_ACK) | take_irq;
  assign tgt_en = (tgt_d != tgt_q);
  assign lo_en  = (state_q == ST_OP_LO) | (state_q == ST_TB_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q <= '0;
    end else if (ret_en) begin
      ret_q <= pc_ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q <= '0;
    end else if (inj_en) begin
      inj_q <= bus_data;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign ack_o         = (state_q == ST_ACK);
  assign oper_o        = (state_q == ST_OP_LO) | (state_q == ST_OP_HI);
  assign tbl_rd_o      = (state_q == ST_TB_LO) | (state_q == ST_TB_HI);
  assign tbl_addr_o    = (state_q == ST_TB_HI) ? {tgt_q[AW-1:1], 1'b1} : tgt_q;
  assign push_o        = (state_q == ST_PUSH_HI) | (state_q == ST_PUSH_LO);
  assign push_data_o   = (state_q == ST_PUSH_HI) ? ret_q[AW-1:DW] : ret_q[DW-1:0];
  assign jump_o        = (state_q == ST_JUMP);
  assign jump_addr_o   = tgt_q;
  assign inject_o      = (state_q == ST_INJECT);
  assign inject_data_o = inj_q;

endmodule

// File: rtl/intr_response_ctl.sv
module intr_response_ctl
  import intr_pkg::*;
#(
  parameter int            ACK_BASE    = 2,
  parameter int            ACK_WAITS   = 2,
  parameter logic [15:0]   NMI_TARGET  = 16'h0066,
  parameter logic [15:0]   IM1_TARGET  = 16'h0038,
  parameter logic [7:0]    CALL_OPCODE = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_in,
  input  logic        irq_in,
  input  logic        at_boundary,
  input  logic        int_en_stb,
  input  logic        int_dis_stb,
  input  logic        mode_stb,
  input  logic [1:0]  mode_sel,
  input  logic        nmi_ret_stb,
  input  logic [7:0]  page_reg,
  input  logic [15:0] pc_ret,
  input  logic [7:0]  bus_data,
  output logic        ack_o,
  output logic        oper_o,
  output logic        tbl_rd_o,
  output logic [15:0] tbl_addr_o,
  output logic        push_o,
  output logic [7:0]  push_data_o,
  output logic        jump_o,
  output logic [15:0] jump_addr_o,
  output logic        inject_o,
  output logic [7:0]  inject_data_o,
  output logic        busy_o,
  output logic        ie_live_o,
  output logic        ie_saved_o,
  output logic [1:0]  mode_o
);

  localparam int ACK_LEN = ACK_BASE + ACK_WAITS;

  logic          take_nmi;
  logic          take_irq;
  logic          nmi_pend;
  resp_kind_t    calc_kind;
  logic [AW-1:0] calc_addr;

  intr_enable_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_stb     (int_en_stb),
    .dis_stb    (int_dis_stb),
    .mode_stb   (mode_stb),
    .mode_sel   (mode_sel),
    .ret_stb    (nmi_ret_stb),
    .take_nmi   (take_nmi),
    .take_irq   (take_irq),
    .ie_live_q  (ie_live_o),
    .ie_saved_q (ie_saved_o),
    .mode_q     (mode_o)
  );

  nmi_edge_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (take_nmi),
    .pend_q (nmi_pend)
  );

  intr_vector_calc #(
    .IM1_TARGET  (IM1_TARGET),
    .CALL_OPCODE (CALL_OPCODE)
  ) u_calc (
    .mode (mode_o),
    .vec  (bus_data),
    .page (page_reg),
    .kind (calc_kind),
    .addr (calc_addr)
  );

  intr_resp_seq #(
    .ACK_LEN    (ACK_LEN),
    .NMI_TARGET (NMI_TARGET)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .at_boundary   (at_boundary),
    .nmi_pend      (nmi_pend),
    .irq_in        (irq_in),
    .ie_live       (ie_live_o),
    .calc_kind     (calc_kind),
    .calc_addr     (calc_addr),
    .pc_ret        (pc_ret),
    .bus_data      (bus_data),
    .take_nmi      (take_nmi),
    .take_irq      (take_irq),
    .ack_o         (ack_o),
    .oper_o        (oper_o),
    .tbl_rd_o      (tbl_rd_o),
    .tbl_addr_o    (tbl_addr_o),
    .push_o        (push_o),
    .push_data_o   (push_data_o),
    .jump_o        (jump_o),
    .jump_addr_o   (jump_addr_o),
    .inject_o      (inject_o),
    .inject_data_o (inject_data_o),
    .busy_o        (busy_o)
  );

endmodule

// File: rtl/intr_response_chk.sv
module intr_response_chk #(
  parameter int ACK_LEN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_o,
  input logic        oper_o,
  input logic        tbl_rd_o,
  input logic [15:0] tbl_addr_o,
  input logic        push_o,
  input logic        jump_o,
  input logic        inject_o,
  input logic        busy_o,
  input logic        ie_live_o,
  input logic        ie_saved_o,
  input logic        int_en_stb,
  input logic        int_dis_stb,
  input logic        nmi_ret_stb,
  input logic        at_boundary,
  input logic [7:0]  page_reg
);

  int ack_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_run <= 0;
    end else begin
      ack_run <= ack_o ? ack_run + 1 : 0;
    end
  end

  assert_ack_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> (ack_run == ACK_LEN));

  assert_ack_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (ack_run < ACK_LEN));

  assert_irq_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> (!ie_live_o && !ie_saved_o));

  assert_nmi_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && push_o) |-> (!ie_live_o && (ie_saved_o == $past(ie_saved_o))));

  assert_ret_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ret_stb && !int_en_stb && !int_dis_stb && !at_boundary) |=> (ie_live_o == $past(ie_saved_o)));

  assert_push_pair_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_o) |=> push_o);

  assert_jump_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(push_o) |-> jump_o);

  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, oper_o, tbl_rd_o, push_o, jump_o, inject_o}));

  assert_tbl_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_o && !$past(tbl_rd_o)) |-> (!tbl_addr_o[0] && (tbl_addr_o[15:8] == page_reg)));

  assert_tbl_second_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_o && $past(tbl_rd_o)) |-> (tbl_addr_o == $past(tbl_addr_o) + 16'd1));

endmodule

bind intr_response_ctl intr_response_chk #(.ACK_LEN(ACK_BASE + ACK_WAITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_o       (ack_o),
  .oper_o      (oper_o),
  .tbl_rd_o    (tbl_rd_o),
  .tbl_addr_o  (tbl_addr_o),
  .push_o      (push_o),
  .jump_o      (jump_o),
  .inject_o    (inject_o),
  .busy_o      (busy_o),
  .ie_live_o   (ie_live_o),
  .ie_saved_o  (ie_saved_o),
  .int_en_stb  (int_en_stb),
  .int_dis_stb (int_dis_stb),
  .nmi_ret_stb (nmi_ret_stb),
  .at_boundary (at_boundary),
  .page_reg    (page_reg)
);

// File: tb/intr_response_ctl_test.sv
module intr_response_ctl_test;

  localparam logic [3:0] EV_ACK  = 4'd1;
  localparam logic [3:0] EV_OPER = 4'd2;
  localparam logic [3:0] EV_TBL  = 4'd3;
  localparam logic [3:0] EV_PUSH = 4'd4;
  localparam logic [3:0] EV_JUMP = 4'd5;
  localparam logic [3:0] EV_INJ  = 4'd6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_in, irq_in, at_boundary;
  logic        int_en_stb, int_dis_stb, mode_stb, nmi_ret_stb;
  logic [1:0]  mode_sel;
  logic [7:0]  page_reg;
  logic [15:0] pc_ret;
  logic [7:0]  bus_data;
  logic        ack_o, oper_o, tbl_rd_o, push_o, jump_o, inject_o, busy_o;
  logic [15:0] tbl_addr_o, jump_addr_o;
  logic [7:0]  push_data_o, inject_data_o;
  logic        ie_live_o, ie_saved_o;
  logic [1:0]  mode_o;

  logic [7:0]  dev_byte, op_lo, op_hi;
  logic        oper_seen;
  logic        running;
  logic        done;
  int          n_cmp;
  int          n_bad;
  int          ack_run;

  logic [19:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  intr_response_ctl uut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
    .at_boundary(at_boundary), .int_en_stb(int_en_stb), .int_dis_stb(int_dis_stb),
    .mode_stb(mode_stb), .mode_sel(mode_sel), .nmi_ret_stb(nmi_ret_stb),
    .page_reg(page_reg), .pc_ret(pc_ret), .bus_data(bus_data),
    .ack_o(ack_o), .oper_o(oper_o), .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o),
    .push_o(push_o), .push_data_o(push_data_o), .jump_o(jump_o),
    .jump_addr_o(jump_addr_o), .inject_o(inject_o), .inject_data_o(inject_data_o),
    .busy_o(busy_o), .ie_live_o(ie_live_o), .ie_saved_o(ie_saved_o), .mode_o(mode_o)
  );

  function automatic logic [7:0] tb_mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Device and memory model on the data bus.
  assign bus_data = tbl_rd_o ? tb_mem(tbl_addr_o)
                  : (oper_o ? (oper_seen ? op_hi : op_lo) : dev_byte);

  always @(posedge clk) begin
    if (!busy_o) oper_seen <= 1'b0;
    else if (oper_o) oper_seen <= 1'b1;
  end

  task automatic expect_ev(input logic [3:0] k, input logic [15:0] v, input string req);
    exp_q.push_back({k, v});
    req_q.push_back(req);
  endtask

  task automatic got_ev(input logic [3:0] k, input logic [15:0] v);
    logic [19:0] e;
    string r;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: kind %0d val %h, expected none", k, v);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      if (e != {k, v}) begin
        n_bad++;
        $display("FAIL %s: got kind %0d val %h, expected kind %0d val %h",
                 r, k, v, e[19:16], e[15:0]);
      end
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: turns output activity into scoreboard events.
  always @(negedge clk) begin
    if (running) begin
      if (ack_o) ack_run++;
      else if (ack_run != 0) begin
        got_ev(EV_ACK, 16'(ack_run));
        ack_run = 0;
      end
      if (oper_o)   got_ev(EV_OPER, 16'h0);
      if (tbl_rd_o) got_ev(EV_TBL, tbl_addr_o);
      if (push_o)   got_ev(EV_PUSH, {8'h00, push_data_o});
      if (jump_o)   got_ev(EV_JUMP, jump_addr_o);
      if (inject_o) got_ev(EV_INJ, {8'h00, inject_data_o});
    end
  end

  task automatic do_en();
    @(negedge clk) int_en_stb = 1'b1;
    @(negedge clk) int_en_stb = 1'b0;
  endtask

  task automatic do_dis();
    @(negedge clk) int_dis_stb = 1'b1;
    @(negedge clk) int_dis_stb = 1'b0;
  endtask

  task automatic do_mode(input logic [1:0] m);
    @(negedge clk) begin mode_stb = 1'b1; mode_sel = m; end
    @(negedge clk) mode_stb = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk) nmi_ret_stb = 1'b1;
    @(negedge clk) nmi_ret_stb = 1'b0;
  endtask

  task automatic nmi_pulse();
    @(negedge clk) nmi_in = 1'b1;
    @(negedge clk) nmi_in = 1'b0;
  endtask

  task automatic boundary_and_wait(input string req);
    @(negedge clk) at_boundary = 1'b1;
    @(negedge clk) at_boundary = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(req, 16'(exp_q.size()), 16'd0);
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic expect_call(input logic [15:0] ret, input logic [15:0] tgt, input string req);
    expect_ev(EV_PUSH, {8'h00, ret[15:8]}, "R13 push high");
    expect_ev(EV_PUSH, {8'h00, ret[7:0]}, "R13 push low");
    expect_ev(EV_JUMP, tgt, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; ack_run = 0; done = 1'b0; running = 1'b0;
    rst_n = 1'b0; nmi_in = 1'b0; irq_in = 1'b0; at_boundary = 1'b0;
    int_en_stb = 1'b0; int_dis_stb = 1'b0; mode_stb = 1'b0; mode_sel = 2'd0;
    nmi_ret_stb = 1'b0; page_reg = 8'h80; pc_ret = 16'h1234;
    dev_byte = 8'h00; op_lo = 8'h00; op_hi = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;

    // R1 reset state
    chk("R1 live bit", {15'd0, ie_live_o}, 16'd0);
    chk("R1 saved bit", {15'd0, ie_saved_o}, 16'd0);
    chk("R1 mode", {14'd0, mode_o}, 16'd0);
    chk("R1 strobes", {10'd0, busy_o, ack_o, push_o, jump_o, inject_o, tbl_rd_o}, 16'd0);

    // R5 request ignored while disabled
    irq_in = 1'b1; dev_byte = 8'h12;
    boundary_and_wait("R5 ignored while disabled");
    chk("R5 still idle", {15'd0, busy_o}, 16'd0);
    irq_in = 1'b0;

    // R2 enable, mode load, mode 3 ignored
    do_en();
    chk("R2 enable live", {15'd0, ie_live_o}, 16'd1);
    chk("R2 enable saved", {15'd0, ie_saved_o}, 16'd1);
    do_mode(2'd1);
    chk("R2 mode load", {14'd0, mode_o}, 16'd1);
    do_mode(2'd3);
    chk("R2 mode 3 ignored", {14'd0, mode_o}, 16'd1);

    // R8 mode 1 restart, device byte irrelevant
    irq_in = 1'b1; dev_byte = 8'hCD; pc_ret = 16'hA1B2;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_call(16'hA1B2, 16'h0038, "R8 mode 1 target");
    boundary_and_wait("R8 sequence complete");
    irq_in = 1'b0;
    chk("R5 accept clears live", {15'd0, ie_live_o}, 16'd0);
    chk("R5 accept clears saved", {15'd0, ie_saved_o}, 16'd0);

    // R9 mode 0 restart opcode 11_101_111
    do_en(); do_mode(2'd0);
    irq_in = 1'b1; dev_byte = 8'hEF; pc_ret = 16'h0456;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_call(16'h0456, 16'h0028, "R9 restart target");
    boundary_and_wait("R9 sequence complete");
    irq_in = 1'b0;

    // R10 mode 0 three-byte call
    do_en();
    irq_in = 1'b1; dev_byte = 8'hCD; op_lo = 8'h34; op_hi = 8'h12; pc_ret = 16'hBEEF;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_ev(EV_OPER, 16'h0, "R10 operand low");
    expect_ev(EV_OPER, 16'h0, "R10 operand high");
    expect_call(16'hBEEF, 16'h1234, "R10 call target");
    boundary_and_wait("R10 sequence complete");
    irq_in = 1'b0;

    // R11 mode 0 other opcode injected
    do_en();
    irq_in = 1'b1; dev_byte = 8'hFB;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_ev(EV_INJ, 16'h00FB, "R11 injected byte");
    boundary_and_wait("R11 sequence complete");
    irq_in = 1'b0;

    // R12 mode 2 vectored call
    do_en(); do_mode(2'd2);
    irq_in = 1'b1; dev_byte = 8'h17; page_reg = 8'h80; pc_ret = 16'h7001;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_ev(EV_TBL, 16'h8016, "R12 table low address");
    expect_ev(EV_TBL, 16'h8017, "R12 table high address");
    expect_call(16'h7001, {tb_mem(16'h8017), tb_mem(16'h8016)}, "R12 vectored target");
    boundary_and_wait("R12 sequence complete");
    irq_in = 1'b0;

    // R3 nonmaskable taken while disabled
    pc_ret = 16'h2345;
    nmi_pulse();
    expect_call(16'h2345, 16'h0066, "R3 nmi target");
    boundary_and_wait("R3 sequence complete");
    chk("R3 live cleared", {15'd0, ie_live_o}, 16'd0);

    // R6 priority, R3 saved bit kept, R4 return
    do_en(); do_mode(2'd1);
    irq_in = 1'b1; pc_ret = 16'h3456;
    nmi_pulse();
    expect_call(16'h3456, 16'h0066, "R6 nmi wins");
    boundary_and_wait("R6 sequence complete");
    chk("R3 live cleared", {15'd0, ie_live_o}, 16'd0);
    chk("R3 saved kept", {15'd0, ie_saved_o}, 16'd1);
    boundary_and_wait("R5 ignored after nmi");
    do_ret();
    chk("R4 live restored", {15'd0, ie_live_o}, 16'd1);
    pc_ret = 16'h4567;
    expect_ev(EV_ACK, 16'd4, "R7 ack length");
    expect_call(16'h4567, 16'h0038, "R4 request taken after return");
    boundary_and_wait("R4 sequence complete");
    irq_in = 1'b0;

    // R3 pending edge waits for a late boundary
    pc_ret = 16'h5678;
    nmi_pulse();
    repeat (5) @(negedge clk);
    expect_call(16'h5678, 16'h0066, "R3 pending edge");
    boundary_and_wait("R3 late boundary");

    // R2 disable
    do_en(); do_dis();
    chk("R2 disable live", {15'd0, ie_live_o}, 16'd0);
    chk("R2 disable saved", {15'd0, ie_saved_o}, 16'd0);

    repeat (3) @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule